// File: doc/BRIEF.md
# Retention Edge-Capture Interrupt Controller

This block sits between a set of external interrupt lines and a main interrupt controller that may be powered down. While the main controller sleeps, the block watches every line through a synchroniser, detects edges of the configured direction and holds each one in a per-line status bit. When firmware later writes the flush command, every held event on an unmasked line is replayed as a single-cycle pulse on that line's output, so no edge that arrived during the sleep period is lost.

Configuration goes through a small 32-bit register bus. Mask, sensitivity and polarity each have a write-one-to-set bank and a write-one-to-clear bank, and an acknowledge bank drops held events without replaying them. Lines map to bit `n mod 32` of word `n div 32` in every bank, and banks are spaced by four bytes per word. The bus is a plain single-cycle write strobe with a combinational read path. It has no valid/ready handshake and no back-pressure: every write is taken on the clock edge where `bus_wr` is high. The pulse outputs are fire-and-forget toward the parent controller.

Top module: `irq_retain`

## Requirements
- R1: Each input passes through a two-flop synchroniser and then an edge detector. A change on `irq_in` made just after clock edge P0 shows in the status readback after edge P0+3 and not after edge P0+2.
- R2: In the set banks (mask 0xC0, sensitivity 0x180, polarity 0x240) and the clear banks (mask 0x100, sensitivity 0x1C0, polarity 0x280), only bits written as 1 change. Bits written as 0 keep their value.
- R3: Line n lives at bit (n mod 32) of the word at bank base + 4*(n div 32). Status reads back at 0x00 + 4*word.
- R4: A line whose sensitivity bit is 1 (level) is never recorded. Sensitivity 0 means edge.
- R5: Polarity 1 records rising edges and polarity 0 records falling edges. An edge in the other direction is not recorded.
- R6: A masked line (mask bit 1) is neither recorded nor flushed. A status bit held before masking survives a flush.
- R7: Writing 1 to a line's bit in the acknowledge bank (0x40) clears its status and leaves the other lines unchanged.
- R8: Writing control (0x300) with bit 2 set while bit 0 is written 1 produces, one cycle after the write edge, exactly one single-cycle pulse on each unmasked line that has status set. Those status bits clear in the same cycle. The flush bit always reads back as 0.
- R9: An edge recorded in the same cycle as that line's flush pulse stays in status and is replayed by the next flush.
- R10: Recording needs control bit 0 (enable) and bit 1 (edge-only mode) both at 1. With enable 0 a flush produces no pulses and held status is kept. Control reads back enable in bit 0 and edge mode in bit 1.
- R11: After reset, status and control read 0, the pulse outputs are low, and every line is masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NUM_WORDS*32 | Asynchronous external interrupt lines |
| bus_wr | input | 1 | Register write strobe, one write per high cycle |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr`, combinational |
| irq_pulse | output | NUM_WORDS*32 | Per-line replay pulse toward the parent controller |

## Verification
A bad configuration bit or a bad status bit shows first as a wrong status word on readback. This is visible three cycles after the offending input change, because the synchroniser and the edge flop sit in front of the status latch. A bad flush path shows one cycle after the control write, as a missing, extra or widened pulse. A status bit left set after it has fired shows up as a second pulse on the next flush. The coincident-edge case is timed so that the new edge lands exactly on the pulse cycle, which exposes a clear that wins over a set.

// File: rtl/irq_retain_pkg.sv
package irq_retain_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFF_STATUS = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_ACK    = 12'h040;
  localparam logic [ADDR_W-1:0] OFF_MSET   = 12'h0C0;
  localparam logic [ADDR_W-1:0] OFF_MCLR   = 12'h100;
  localparam logic [ADDR_W-1:0] OFF_SSET   = 12'h180;
  localparam logic [ADDR_W-1:0] OFF_SCLR   = 12'h1C0;
  localparam logic [ADDR_W-1:0] OFF_PSET   = 12'h240;
  localparam logic [ADDR_W-1:0] OFF_PCLR   = 12'h280;
  localparam logic [ADDR_W-1:0] OFF_CTRL   = 12'h300;

  // control word bit positions (software decodes these)
  localparam int CTRL_EN_BIT    = 0;
  localparam int CTRL_EDGE_BIT  = 1;
  localparam int CTRL_FLUSH_BIT = 2;

  function automatic logic [ADDR_W-1:0] word_addr(logic [ADDR_W-1:0] base, int w);
    return base + ADDR_W'(w * 4);
  endfunction
endpackage

// File: rtl/irq_retain_sync.sv
module irq_retain_sync #(
  parameter int WIDTH  = 64,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= async_in;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/irq_retain_regs.sv
module irq_retain_regs
  import irq_retain_pkg::*;
#(
  parameter int NUM_WORDS = 2,
  localparam int LINES = NUM_WORDS * 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [LINES-1:0]  status,
  output logic [LINES-1:0]  mask,
  output logic [LINES-1:0]  sens,
  output logic [LINES-1:0]  pol,
  output logic [LINES-1:0]  ack_vec,
  output logic              en,
  output logic              edge_mode,
  output logic              flush_go
);
  logic [LINES-1:0] mask_q, sens_q, pol_q;

  genvar w;
  generate
    for (w = 0; w < NUM_WORDS; w++) begin : g_word
      logic mset_hit, mclr_hit, sset_hit, sclr_hit, pset_hit, pclr_hit, ack_hit;
      assign mset_hit = bus_wr && (bus_addr == word_addr(OFF_MSET, w));
      assign mclr_hit = bus_wr && (bus_addr == word_addr(OFF_MCLR, w));
      assign sset_hit = bus_wr && (bus_addr == word_addr(OFF_SSET, w));
      assign sclr_hit = bus_wr && (bus_addr == word_addr(OFF_SCLR, w));
      assign pset_hit = bus_wr && (bus_addr == word_addr(OFF_PSET, w));
      assign pclr_hit = bus_wr && (bus_addr == word_addr(OFF_PCLR, w));
      assign ack_hit  = bus_wr && (bus_addr == word_addr(OFF_ACK, w));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mask_q[w*32 +: 32] <= '1;
          sens_q[w*32 +: 32] <= '0;
          pol_q[w*32 +: 32]  <= '0;
        end else begin
          if (mset_hit)      mask_q[w*32 +: 32] <= mask_q[w*32 +: 32] | bus_wdata;
          else if (mclr_hit) mask_q[w*32 +: 32] <= mask_q[w*32 +: 32] & ~bus_wdata;
          if (sset_hit)      sens_q[w*32 +: 32] <= sens_q[w*32 +: 32] | bus_wdata;
          else if (sclr_hit) sens_q[w*32 +: 32] <= sens_q[w*32 +: 32] & ~bus_wdata;
          if (pset_hit)      pol_q[w*32 +: 32]  <= pol_q[w*32 +: 32] | bus_wdata;
          else if (pclr_hit) pol_q[w*32 +: 32]  <= pol_q[w*32 +: 32] & ~bus_wdata;
        end
      end

      assign ack_vec[w*32 +: 32] = ack_hit ? bus_wdata : '0;
    end
  endgenerate

  logic ctrl_hit;
  assign ctrl_hit = bus_wr && (bus_addr == OFF_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en        <= 1'b0;
      edge_mode <= 1'b0;
      flush_go  <= 1'b0;
    end else begin
      flush_go <= 1'b0;
      if (ctrl_hit) begin
        en        <= bus_wdata[CTRL_EN_BIT];
        edge_mode <= bus_wdata[CTRL_EDGE_BIT];
        flush_go  <= bus_wdata[CTRL_FLUSH_BIT];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_WORDS; i++) begin
      if (bus_addr == word_addr(OFF_STATUS, i)) bus_rdata = status[i*32 +: 32];
    end
    if (bus_addr == OFF_CTRL) begin
      bus_rdata[CTRL_EN_BIT]   = en;
      bus_rdata[CTRL_EDGE_BIT] = edge_mode;
    end
  end

  assign mask = mask_q;
  assign sens = sens_q;
  assign pol  = pol_q;
endmodule

// File: rtl/irq_retain_capture.sv
module irq_retain_capture #(
  parameter int LINES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] sync_in,
  input  logic [LINES-1:0] mask,
  input  logic [LINES-1:0] sens,
  input  logic [LINES-1:0] pol,
  input  logic [LINES-1:0] ack_vec,
  input  logic             en,
  input  logic             edge_mode,
  input  logic             flush_go,
  output logic [LINES-1:0] status,
  output logic [LINES-1:0] irq_pulse
);
  logic [LINES-1:0] prev_q, rise, fall, hit, rec, fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sync_in;
  end

  assign rise = sync_in & ~prev_q;
  assign fall = ~sync_in & prev_q;
  assign hit  = (pol & rise) | (~pol & fall);
  assign rec  = {LINES{en & edge_mode}} & ~sens & ~mask & hit;
  assign fire = {LINES{flush_go & en}} & status & ~mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status    <= '0;
      irq_pulse <= '0;
    end else begin
      status    <= (status & ~fire & ~ack_vec) | rec;
      irq_pulse <= fire;
    end
  end

  // R4
  level_never_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ~$past(status)) & $past(sens)) == '0);
  // R6
  masked_never_pulsed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pulse & $past(mask)) == '0);
  // R10
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> (irq_pulse == '0));
  // R8
  pulse_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pulse & ~$past(status)) == '0);
endmodule

// File: rtl/irq_retain.sv
module irq_retain
  import irq_retain_pkg::*;
#(
  parameter int NUM_WORDS   = 2,
  parameter int SYNC_STAGES = 2,
  localparam int LINES = NUM_WORDS * 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  irq_in,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [LINES-1:0]  irq_pulse
);
  logic [LINES-1:0] sync_lv, mask, sens, pol, ack_vec, status;
  logic en, edge_mode, flush_go;

  irq_retain_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(irq_in), .sync_out(sync_lv));

  irq_retain_regs #(.NUM_WORDS(NUM_WORDS)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .status(status),
    .mask(mask), .sens(sens), .pol(pol), .ack_vec(ack_vec),
    .en(en), .edge_mode(edge_mode), .flush_go(flush_go));

  irq_retain_capture #(.LINES(LINES)) u_cap (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_lv), .mask(mask), .sens(sens),
    .pol(pol), .ack_vec(ack_vec), .en(en), .edge_mode(edge_mode),
    .flush_go(flush_go), .status(status), .irq_pulse(irq_pulse));
endmodule

// File: tb/irq_retain_tb.sv
module irq_retain_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irq_in = '0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] irq_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [63:0] exp_q [$];
  logic [31:0] rv;

  always #10 clk = ~clk;

  irq_retain u_dut (.clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_pulse(irq_pulse));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic settle();
    repeat (5) @(posedge clk); #1;
  endtask

  task automatic chk_rd(input logic [11:0] a, input logic [31:0] exp, input string req);
    logic [31:0] v;
    rd(a, v);
    chk(v == exp, req, {32'h0, v}, {32'h0, exp});
  endtask

  // scoreboard monitor: every nonzero pulse vector must match the next expected one
  always @(negedge clk) begin
    if (rst_n && irq_pulse != '0) begin
      if (exp_q.size() == 0) chk(1'b0, "R8 unexpected pulse", irq_pulse, 64'h0);
      else begin
        logic [63:0] e;
        e = exp_q.pop_front();
        chk(irq_pulse == e, "R8 pulse vector", irq_pulse, e);
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    // R11 reset state
    chk(irq_pulse == '0, "R11 pulses low", irq_pulse, 64'h0);
    chk_rd(12'h000, 32'h0, "R11 status w0");
    chk_rd(12'h004, 32'h0, "R11 status w1");
    chk_rd(12'h300, 32'h0, "R11 ctrl");
    // R11 every line masked after reset: enabled edge is not recorded
    wr(12'h300, 32'h3);
    @(posedge clk); #1 irq_in[0] = 1'b1;
    wr(12'h240, 32'h1);
    settle();
    chk_rd(12'h000, 32'h0, "R11 masked at reset");
    irq_in[0] = 1'b0;
    wr(12'h300, 32'h0);
    settle();

    wr(12'h100, 32'hFFFF_FFFF);
    wr(12'h104, 32'hFFFF_FFFF);
    wr(12'h240, 32'hFFFF_FFFF);   // word 0 rising, word 1 falling
    // R10 edges while disabled are ignored
    irq_in = {32'hFFFF_FFFF, 32'h4};
    settle();
    wr(12'h300, 32'h3);
    settle();
    chk_rd(12'h000, 32'h0, "R10 disabled no record w0");
    chk_rd(12'h004, 32'h0, "R10 disabled no record w1");
    chk_rd(12'h300, 32'h3, "R10 ctrl readback");

    // R1 synchroniser latency
    @(posedge clk); #1 irq_in[3] = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    chk_rd(12'h000, 32'h0, "R1 not yet after two edges");
    @(posedge clk); #1;
    chk_rd(12'h000, 32'h8, "R1 recorded after three edges");

    // R5 / R3 polarity and word mapping
    irq_in[40] = 1'b0;   // falling on falling-polarity line -> w1 bit 8
    irq_in[2]  = 1'b0;   // falling on rising-polarity line -> ignored
    settle();
    chk_rd(12'h000, 32'h8, "R5 wrong-direction edge ignored");
    chk_rd(12'h004, 32'h100, "R3 line 40 at word1 bit8");

    // R2 set bank touches only ones
    wr(12'h0C0, 32'h10);
    irq_in[4] = 1'b1; irq_in[6] = 1'b1;
    settle();
    chk_rd(12'h000, 32'h48, "R2 only line4 masked");

    // R4 level lines not latched
    wr(12'h180, 32'h80);
    irq_in[7] = 1'b1;
    settle();
    chk_rd(12'h000, 32'h48, "R4 level line ignored");

    // R7 acknowledge
    irq_in[5] = 1'b1;
    settle();
    chk_rd(12'h000, 32'h68, "R7 line5 recorded");
    wr(12'h040, 32'h20);
    settle();
    chk_rd(12'h000, 32'h48, "R7 ack cleared only line5");

    // R6 masked held status survives, R8 flush
    wr(12'h0C0, 32'h40);
    exp_q.push_back({32'h100, 32'h8});
    wr(12'h300, 32'h7);
    settle();
    chk_rd(12'h000, 32'h40, "R6 masked status kept");
    chk_rd(12'h004, 32'h0, "R8 flushed status cleared");
    chk_rd(12'h300, 32'h3, "R8 flush reads zero");

    // R9 edge coinciding with pulse stays
    irq_in[10] = 1'b1; settle();
    irq_in[10] = 1'b0; settle();
    chk_rd(12'h000, 32'h440, "R9 line10 held");
    @(posedge clk); #1 irq_in[10] = 1'b1;
    exp_q.push_back(64'h400);
    wr(12'h300, 32'h7);
    settle();
    chk_rd(12'h000, 32'h440, "R9 coincident edge kept");
    exp_q.push_back(64'h400);
    wr(12'h300, 32'h7);
    settle();
    chk_rd(12'h000, 32'h40, "R9 replayed once more");

    // R10 edge mode off, then enable off with flush
    wr(12'h300, 32'h1);
    irq_in[12] = 1'b1;
    settle();
    chk_rd(12'h000, 32'h40, "R10 no record without edge mode");
    wr(12'h100, 32'h40);
    wr(12'h300, 32'h4);
    settle();
    chk_rd(12'h000, 32'h40, "R10 disabled flush keeps status");
    chk_rd(12'h300, 32'h0, "R10 ctrl readback zero");
    exp_q.push_back(64'h40);
    wr(12'h300, 32'h7);
    settle();
    chk_rd(12'h000, 32'h0, "R8 final flush cleared");
    chk(exp_q.size() == 0, "R8 all expected pulses seen", 64'(exp_q.size()), 64'h0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule